// File: doc/BRIEF.md
# Transceiver Operating-Mode Sequencer

This block turns a chip-level enable pin and a 3-bit operating-mode selector into the power-up enables of a multi-channel transceiver. The outputs cover the crystal oscillator, the buffered reference clock output, the synthesizer and LO chain, the receive path (with separate LNA and I/Q-buffer enables), the transmit path with per-channel enables, the transmit-calibration amplitude detector and its one-hot channel select, the transmit lowpass bypass, and the two loopback routings.

It also gates the bias outputs of the external power amplifiers. When the transceiver enters transmit, a counter starts, and the bias is released only after a programmable number of cycles. A keep-on control holds the bias in every powered mode. A per-channel allow mask can hold any amplifier off.

Every output is registered. Every output reflects the inputs that were present at the previous rising clock edge, so the block has a latency of one cycle. Reset is synchronous and active high.

Top module: `xcvr_mode_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every output is 0 after that edge.
- R2: With `en_pin` low (shutdown), every output is 0 one cycle later, whatever `mode_sel`, `pa_keep_on` and the other inputs are.
- R3: `clkout_en` equals `en_pin` one cycle earlier, in every mode. With `en_pin` high and `mode_sel` = 000 (clock-out), only `osc_en` and `clkout_en` are 1.
- R4: `mode_sel` = 001 (standby) and the unused code 111 both give `osc_en`, `clkout_en` and `synth_en` only.
- R5: `mode_sel` = 010 (receive) adds `rx_en`, `lna_en` and `rxbuf_en` to the standby set.
- R6: `mode_sel` = 011 (transmit) adds `tx_en`, with `tx_chan_en` all ones, to the standby set.
- R7: `mode_sel` = 100 (transmit calibration) adds `tx_en`, `tx_chan_en` all ones, `amdet_en` and `rxbuf_en` to the standby set. `amdet_sel` is one-hot with bit `det_sel` set. In every other mode `amdet_sel` is 0.
- R8: `mode_sel` = 101 (RF loopback) adds `tx_en`, `rx_en`, `rxbuf_en`, `lpf_bypass` and `lpbk_rf_en` to the standby set. `tx_chan_en` is 4'b1000, so only the highest channel is on, and `lna_en` is 0.
- R9: `mode_sel` = 110 (baseband loopback) adds `tx_en`, `rx_en`, `rxbuf_en` and `lpbk_bb_en` to the standby set. `tx_chan_en` is 4'b1000, and `lna_en` and `lpf_bypass` are 0.
- R10: With `pa_keep_on` low in transmit, `pa_bias_en` rises exactly `pa_delay` cycles after `tx_en` rises. With a delay of 0 it rises in the same cycle as `tx_en`.
- R11: With `pa_keep_on` low, leaving transmit clears `pa_bias_en` one cycle later. The next entry to transmit restarts the delay count from zero.
- R12: With `pa_keep_on` high, `pa_bias_en` is on, with no delay, in standby, receive, transmit, transmit calibration and both loopbacks. It stays 0 in shutdown and clock-out.
- R13: Bit i of `pa_bias_en` can be 1 only if bit i of `pa_chan_en` was 1 one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_pin | input | 1 | Chip enable pin; low means shutdown |
| mode_sel | input | 3 | Operating-mode code |
| det_sel | input | 2 | Transmitter feeding the calibration detector |
| pa_delay | input | 8 | Cycles from transmit entry to PA bias release |
| pa_keep_on | input | 1 | Hold PA bias in all powered modes |
| pa_chan_en | input | 4 | Per-channel PA bias allow mask |
| osc_en | output | 1 | Crystal oscillator enable |
| clkout_en | output | 1 | Reference clock output enable |
| synth_en | output | 1 | Synthesizer, VCO and LO enable |
| rx_en | output | 1 | Receive path enable |
| lna_en | output | 1 | Low-noise amplifier enable |
| rxbuf_en | output | 1 | Receive I/Q buffer enable |
| tx_en | output | 1 | Transmit path enable |
| tx_chan_en | output | 4 | Per-channel transmit enable |
| amdet_en | output | 1 | Calibration amplitude detector enable |
| amdet_sel | output | 4 | One-hot detector channel select |
| lpf_bypass | output | 1 | Transmit lowpass bypass |
| lpbk_rf_en | output | 1 | RF loopback routing enable |
| lpbk_bb_en | output | 1 | Baseband loopback routing enable |
| pa_bias_en | output | 4 | External PA bias enables |

## Verification
The assertions check the following on every cycle:
- Shutdown forces every output to zero.
- The clock output tracks only the pin.
- The detector select stays one-hot or zero.
- Loopback never enables the LNA, and the two loopbacks are never on together.
- PA bias is never on without the synthesizer, never on against the allow mask, and always drops when leaving transmit without keep-on.

Only the bench's scenarios can show the exact enable set of each mode code and the exact cycle of bias release for a chosen delay. The same holds for the restart of the count on re-entry and the immediate bias under keep-on.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;

    typedef enum logic [2:0] {
        OPM_OFF,
        OPM_CLKO,
        OPM_STBY,
        OPM_RX,
        OPM_TX,
        OPM_TXCAL,
        OPM_RFLB,
        OPM_BBLB
    } op_mode_e;

    localparam logic [2:0] SEL_CLKO  = 3'b000;
    localparam logic [2:0] SEL_STBY  = 3'b001;
    localparam logic [2:0] SEL_RX    = 3'b010;
    localparam logic [2:0] SEL_TX    = 3'b011;
    localparam logic [2:0] SEL_TXCAL = 3'b100;
    localparam logic [2:0] SEL_RFLB  = 3'b101;
    localparam logic [2:0] SEL_BBLB  = 3'b110;

    // Single-bit block enables driven straight to the ports
    typedef struct packed {
        logic osc;
        logic clko;
        logic synth;
        logic rx;
        logic lna;
        logic rxbuf;
        logic tx;
        logic amdet;
        logic lpf_byp;
        logic lb_rf;
        logic lb_bb;
    } port_en_t;

    // Full decode result, including transmit-channel policy
    typedef struct packed {
        port_en_t pe;
        logic     all_tx;
        logic     top_ch_only;
    } blk_en_t;

    function automatic op_mode_e decode_mode(input logic pin, input logic [2:0] sel);
        op_mode_e m;
        if (!pin) begin
            m = OPM_OFF;
        end else begin
            case (sel)
                SEL_CLKO:  m = OPM_CLKO;
                SEL_RX:    m = OPM_RX;
                SEL_TX:    m = OPM_TX;
                SEL_TXCAL: m = OPM_TXCAL;
                SEL_RFLB:  m = OPM_RFLB;
                SEL_BBLB:  m = OPM_BBLB;
                default:   m = OPM_STBY;
            endcase
        end
        return m;
    endfunction

    function automatic blk_en_t enables_of(input op_mode_e m);
        blk_en_t e;
        e = '0;
        if (m != OPM_OFF) begin
            e.pe.osc  = 1'b1;
            e.pe.clko = 1'b1;
        end
        if (m != OPM_OFF && m != OPM_CLKO) begin
            e.pe.synth = 1'b1;
        end
        case (m)
            OPM_RX: begin
                e.pe.rx    = 1'b1;
                e.pe.lna   = 1'b1;
                e.pe.rxbuf = 1'b1;
            end
            OPM_TX: begin
                e.pe.tx  = 1'b1;
                e.all_tx = 1'b1;
            end
            OPM_TXCAL: begin
                e.pe.tx    = 1'b1;
                e.all_tx   = 1'b1;
                e.pe.amdet = 1'b1;
                e.pe.rxbuf = 1'b1;
            end
            OPM_RFLB: begin
                e.pe.tx      = 1'b1;
                e.top_ch_only = 1'b1;
                e.pe.rx      = 1'b1;
                e.pe.rxbuf   = 1'b1;
                e.pe.lpf_byp = 1'b1;
                e.pe.lb_rf   = 1'b1;
            end
            OPM_BBLB: begin
                e.pe.tx      = 1'b1;
                e.top_ch_only = 1'b1;
                e.pe.rx      = 1'b1;
                e.pe.rxbuf   = 1'b1;
                e.pe.lb_bb   = 1'b1;
            end
            default: ;
        endcase
        return e;
    endfunction

    // Modes in which the keep-on control may hold PA bias
    function automatic logic bias_hold_ok(input op_mode_e m);
        return (m != OPM_OFF) && (m != OPM_CLKO);
    endfunction

endpackage

// File: rtl/xcvr_mode_decode.sv
module xcvr_mode_decode
    import xcvr_mode_pkg::*;
(
    input  logic       en_pin,
    input  logic [2:0] mode_sel,
    output op_mode_e   mode_n
);

    always_comb begin
        mode_n = decode_mode(en_pin, mode_sel);
    end

endmodule

// File: rtl/xcvr_enable_reg.sv
module xcvr_enable_reg
    import xcvr_mode_pkg::*;
#(
    parameter int NUM_TX = 4,
    localparam int SEL_W = (NUM_TX > 1) ? $clog2(NUM_TX) : 1,
    localparam int TOP_CH = NUM_TX - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  op_mode_e          mode_n,
    input  logic [SEL_W-1:0]  det_sel,
    output port_en_t          en_q,
    output logic [NUM_TX-1:0] tx_chan_q,
    output logic [NUM_TX-1:0] amsel_q
);

    blk_en_t en_n;

    always_comb begin
        en_n = enables_of(mode_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            en_q <= en_n.pe;
        end
    end

    for (genvar ch = 0; ch < NUM_TX; ch++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                tx_chan_q[ch] <= 1'b0;
                amsel_q[ch]   <= 1'b0;
            end else begin
                tx_chan_q[ch] <= en_n.all_tx || (en_n.top_ch_only && (ch == TOP_CH));
                amsel_q[ch]   <= en_n.pe.amdet && (det_sel == SEL_W'(ch));
            end
        end
    end

endmodule

// File: rtl/xcvr_pa_timer.sv
module xcvr_pa_timer
    import xcvr_mode_pkg::*;
#(
    parameter int NUM_TX = 4,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  op_mode_e          mode_n,
    input  logic [DLY_W-1:0]  pa_delay,
    input  logic              pa_keep_on,
    input  logic [NUM_TX-1:0] pa_chan_en,
    output logic [NUM_TX-1:0] pa_bias_en
);

    logic              tx_n;
    logic              tx_q;
    logic [DLY_W-1:0]  cnt_n;
    logic [DLY_W-1:0]  cnt_q;
    logic              rel_q;
    logic              hold_q;
    logic [NUM_TX-1:0] allow_q;

    assign tx_n = (mode_n == OPM_TX);

    // Count restarts at zero on every entry and saturates at the delay
    always_comb begin
        cnt_n = '0;
        if (tx_n && tx_q) begin
            cnt_n = (cnt_q < pa_delay) ? cnt_q + DLY_W'(1) : cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q    <= 1'b0;
            cnt_q   <= '0;
            rel_q   <= 1'b0;
            hold_q  <= 1'b0;
            allow_q <= '0;
        end else begin
            tx_q    <= tx_n;
            cnt_q   <= cnt_n;
            rel_q   <= tx_n && (cnt_n >= pa_delay);
            hold_q  <= pa_keep_on && bias_hold_ok(mode_n);
            allow_q <= pa_chan_en;
        end
    end

    for (genvar ch = 0; ch < NUM_TX; ch++) begin : g_bias
        assign pa_bias_en[ch] = allow_q[ch] & (rel_q | hold_q);
    end

endmodule

// File: rtl/xcvr_mode_seq.sv
module xcvr_mode_seq
    import xcvr_mode_pkg::*;
#(
    parameter int NUM_TX = 4,
    parameter int DLY_W  = 8,
    localparam int SEL_W = (NUM_TX > 1) ? $clog2(NUM_TX) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_pin,
    input  logic [2:0]        mode_sel,
    input  logic [SEL_W-1:0]  det_sel,
    input  logic [DLY_W-1:0]  pa_delay,
    input  logic              pa_keep_on,
    input  logic [NUM_TX-1:0] pa_chan_en,
    output logic              osc_en,
    output logic              clkout_en,
    output logic              synth_en,
    output logic              rx_en,
    output logic              lna_en,
    output logic              rxbuf_en,
    output logic              tx_en,
    output logic [NUM_TX-1:0] tx_chan_en,
    output logic              amdet_en,
    output logic [NUM_TX-1:0] amdet_sel,
    output logic              lpf_bypass,
    output logic              lpbk_rf_en,
    output logic              lpbk_bb_en,
    output logic [NUM_TX-1:0] pa_bias_en
);

    op_mode_e mode_n;
    port_en_t en_q;

    xcvr_mode_decode u_dec (
        .en_pin   (en_pin),
        .mode_sel (mode_sel),
        .mode_n   (mode_n)
    );

    xcvr_enable_reg #(.NUM_TX(NUM_TX)) u_en (
        .clk       (clk),
        .rst       (rst),
        .mode_n    (mode_n),
        .det_sel   (det_sel),
        .en_q      (en_q),
        .tx_chan_q (tx_chan_en),
        .amsel_q   (amdet_sel)
    );

    xcvr_pa_timer #(.NUM_TX(NUM_TX), .DLY_W(DLY_W)) u_pa (
        .clk        (clk),
        .rst        (rst),
        .mode_n     (mode_n),
        .pa_delay   (pa_delay),
        .pa_keep_on (pa_keep_on),
        .pa_chan_en (pa_chan_en),
        .pa_bias_en (pa_bias_en)
    );

    assign osc_en     = en_q.osc;
    assign clkout_en  = en_q.clko;
    assign synth_en   = en_q.synth;
    assign rx_en      = en_q.rx;
    assign lna_en     = en_q.lna;
    assign rxbuf_en   = en_q.rxbuf;
    assign tx_en      = en_q.tx;
    assign amdet_en   = en_q.amdet;
    assign lpf_bypass = en_q.lpf_byp;
    assign lpbk_rf_en = en_q.lb_rf;
    assign lpbk_bb_en = en_q.lb_bb;

endmodule

// File: rtl/xcvr_mode_chk.sv
module xcvr_mode_chk #(
    parameter int NUM_TX = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              en_pin,
    input logic [2:0]        mode_sel,
    input logic              pa_keep_on,
    input logic [NUM_TX-1:0] pa_chan_en,
    input logic              osc_en,
    input logic              clkout_en,
    input logic              synth_en,
    input logic              rx_en,
    input logic              lna_en,
    input logic              rxbuf_en,
    input logic              tx_en,
    input logic [NUM_TX-1:0] tx_chan_en,
    input logic              amdet_en,
    input logic [NUM_TX-1:0] amdet_sel,
    input logic              lpf_bypass,
    input logic              lpbk_rf_en,
    input logic              lpbk_bb_en,
    input logic [NUM_TX-1:0] pa_bias_en
);

    // R2: shutdown clears every output on the next cycle
    a_r2_shutdown_off: assert property (@(posedge clk) disable iff (rst)
        !en_pin |=> !(osc_en | clkout_en | synth_en | rx_en | lna_en | rxbuf_en | tx_en |
                      amdet_en | lpf_bypass | lpbk_rf_en | lpbk_bb_en) &&
                    (tx_chan_en == '0) && (amdet_sel == '0) && (pa_bias_en == '0));

    // R3: the clock output follows the pin alone
    a_r3_clkout_pin: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (clkout_en == $past(en_pin)));

    // R7: the detector select is one-hot and present only with the detector
    a_r7_amsel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(amdet_sel) && ((amdet_sel != '0) == amdet_en));

    // R8: no loopback uses the LNA, and the two loopbacks never overlap
    a_r8_loop_no_lna: assert property (@(posedge clk) disable iff (rst)
        (lpbk_rf_en || lpbk_bb_en) |-> (!lna_en && !(lpbk_rf_en && lpbk_bb_en)));

    // R11: leaving transmit without keep-on drops the bias
    a_r11_pa_drop: assert property (@(posedge clk) disable iff (rst)
        (!pa_keep_on && !(en_pin && mode_sel == 3'b011)) |=> (pa_bias_en == '0));

    // R12: bias only in modes where the synthesizer runs
    a_r12_pa_needs_synth: assert property (@(posedge clk) disable iff (rst)
        (|pa_bias_en) |-> synth_en);

    // R13: a channel outside the allow mask never gets bias
    a_r13_pa_mask: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pa_bias_en & ~$past(pa_chan_en)) == '0));

endmodule

bind xcvr_mode_seq xcvr_mode_chk #(.NUM_TX(NUM_TX)) u_chk (.*);

// File: tb/sim_xcvr_mode_seq.sv
module sim_xcvr_mode_seq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_pin = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic [1:0] det_sel = 2'b00;
    logic [7:0] pa_delay = 8'd0;
    logic       pa_keep_on = 1'b0;
    logic [3:0] pa_chan_en = 4'b0000;

    logic       osc_en, clkout_en, synth_en, rx_en, lna_en, rxbuf_en, tx_en;
    logic [3:0] tx_chan_en, amdet_sel, pa_bias_en;
    logic       amdet_en, lpf_bypass, lpbk_rf_en, lpbk_bb_en;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xcvr_mode_seq u0 (
        .clk(clk), .rst(rst), .en_pin(en_pin), .mode_sel(mode_sel), .det_sel(det_sel),
        .pa_delay(pa_delay), .pa_keep_on(pa_keep_on), .pa_chan_en(pa_chan_en),
        .osc_en(osc_en), .clkout_en(clkout_en), .synth_en(synth_en), .rx_en(rx_en),
        .lna_en(lna_en), .rxbuf_en(rxbuf_en), .tx_en(tx_en), .tx_chan_en(tx_chan_en),
        .amdet_en(amdet_en), .amdet_sel(amdet_sel), .lpf_bypass(lpf_bypass),
        .lpbk_rf_en(lpbk_rf_en), .lpbk_bb_en(lpbk_bb_en), .pa_bias_en(pa_bias_en)
    );

    typedef struct {
        logic [22:0] v;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fails = 0;
    bit    done = 1'b0;
    int    k = 0;
    bit    prev_tx = 1'b0;

    wire [22:0] obs = {osc_en, clkout_en, synth_en, rx_en, lna_en, rxbuf_en, tx_en,
                       amdet_en, lpf_bypass, lpbk_rf_en, lpbk_bb_en,
                       tx_chan_en, amdet_sel, pa_bias_en};

    function automatic logic [22:0] model(bit pin, bit [2:0] code, bit [1:0] sel, bit [3:0] pa);
        logic osc, clko, syn, rx, lna, rb, tx, am, byp, lr, lb;
        logic [3:0] tch, ams;
        {osc, clko, syn, rx, lna, rb, tx, am, byp, lr, lb} = '0;
        tch = '0;
        ams = '0;
        if (pin) begin
            osc = 1'b1;
            clko = 1'b1;
            case (code)
                3'd0: ;
                3'd2: begin syn = 1; rx = 1; lna = 1; rb = 1; end
                3'd3: begin syn = 1; tx = 1; tch = 4'hF; end
                3'd4: begin syn = 1; tx = 1; tch = 4'hF; am = 1; rb = 1; ams = 4'b0001 << sel; end
                3'd5: begin syn = 1; tx = 1; tch = 4'b1000; rx = 1; rb = 1; byp = 1; lr = 1; end
                3'd6: begin syn = 1; tx = 1; tch = 4'b1000; rx = 1; rb = 1; lb = 1; end
                default: syn = 1;
            endcase
        end
        return {osc, clko, syn, rx, lna, rb, tx, am, byp, lr, lb, tch, ams, pa};
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected outputs
    task automatic step(bit pin, bit [2:0] code, int dly, bit keep, bit [3:0] allow,
                        bit [1:0] sel, string tag);
        bit txm, rel, hold;
        item_t it;
        @(negedge clk);
        en_pin = pin;
        mode_sel = code;
        pa_delay = 8'(dly);
        pa_keep_on = keep;
        pa_chan_en = allow;
        det_sel = sel;
        txm = pin && (code == 3'd3);
        if (txm) k = prev_tx ? k + 1 : 0;
        else k = 0;
        prev_tx = txm;
        rel = txm && (k >= dly);
        hold = keep && pin && (code != 3'd0);
        it.v = model(pin, code, sel, allow & {4{rel | hold}});
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compares after each rising edge, away from the edge
    always @(posedge clk) begin
        item_t it;
        #1;
        if (!rst && q.size() > 0) begin
            it = q.pop_front();
            n_checks++;
            if (obs !== it.v) begin
                n_fails++;
                $display("FAIL %s: got %h expected %h", it.tag, obs, it.v);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state with active-looking inputs
        en_pin = 1'b1; mode_sel = 3'd3; pa_keep_on = 1'b1; pa_chan_en = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if (obs !== 23'h0) begin
            n_fails++;
            $display("FAIL R1: got %h expected %h", obs, 23'h0);
        end
        @(negedge clk);
        en_pin = 1'b0; pa_keep_on = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // R2: pin low wins over any code and keep-on
        step(0, 3'd3, 0, 1, 4'hF, 0, "R2");
        step(0, 3'd4, 0, 1, 4'hF, 2, "R2");
        // R3: clock-out only; keep-on ignored here (R12)
        step(1, 3'd0, 0, 1, 4'hF, 0, "R3");
        step(1, 3'd0, 0, 0, 4'hF, 0, "R3");
        // R4: standby and the unused code
        step(1, 3'd1, 0, 0, 4'hF, 0, "R4");
        step(1, 3'd7, 0, 0, 4'hF, 0, "R4");
        // R5: receive
        step(1, 3'd2, 0, 0, 4'hF, 0, "R5");
        // R6 and R10: transmit with delay 3
        for (int i = 0; i < 6; i++) step(1, 3'd3, 3, 0, 4'hF, 0, "R6_R10");
        // R11: exit clears, re-entry restarts the count
        step(1, 3'd1, 3, 0, 4'hF, 0, "R11");
        for (int i = 0; i < 5; i++) step(1, 3'd3, 3, 0, 4'hF, 0, "R11");
        step(1, 3'd2, 3, 0, 4'hF, 0, "R11");
        // R10: zero delay releases with tx entry
        step(1, 3'd3, 0, 0, 4'hF, 0, "R10");
        step(1, 3'd3, 0, 0, 4'hF, 0, "R10");
        step(1, 3'd1, 0, 0, 4'hF, 0, "R11");
        // R7: calibration detector select for every channel
        for (int s = 0; s < 4; s++) step(1, 3'd4, 0, 0, 4'hF, 2'(s), "R7");
        // R8 and R9: loopbacks
        step(1, 3'd5, 0, 0, 4'hF, 1, "R8");
        step(1, 3'd6, 0, 0, 4'hF, 3, "R9");
        // R12: keep-on across modes
        step(1, 3'd1, 5, 1, 4'hF, 0, "R12");
        step(1, 3'd2, 5, 1, 4'hF, 0, "R12");
        step(1, 3'd3, 5, 1, 4'hF, 0, "R12");
        step(1, 3'd4, 5, 1, 4'hF, 0, "R12");
        step(1, 3'd5, 5, 1, 4'hF, 0, "R12");
        step(1, 3'd6, 5, 1, 4'hF, 0, "R12");
        step(1, 3'd0, 5, 1, 4'hF, 0, "R12");
        step(0, 3'd1, 5, 1, 4'hF, 0, "R12");
        // R13: allow mask during transmit and during keep-on
        for (int i = 0; i < 3; i++) step(1, 3'd3, 1, 0, 4'b0101, 0, "R13");
        step(1, 3'd3, 1, 0, 4'b0010, 0, "R13");
        step(1, 3'd2, 1, 1, 4'b1000, 0, "R13");
        // R2: pin drop straight out of transmit
        step(1, 3'd3, 0, 0, 4'hF, 0, "R2");
        step(0, 3'd3, 0, 0, 4'hF, 0, "R2");
        step(1, 3'd1, 0, 0, 4'hF, 0, "R4");

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule